// File: doc/BRIEF.md
# Two-Processor Coherence Directory

This block sits between two processor buses and a single memory port. For each cache line in an aligned shared address window it records the state each processor's cache holds: Invalid, Shared or Modified. It uses that record to decide whether an access also needs an action on the other bus. Accesses outside the window go straight to memory and do not touch the record. Inside the window, the other cache is invalidated, flushed or downgraded only when its recorded state calls for it. The requester is stalled until that forward completes.

Reads inside the window pulse a shared indication back to the requesting cache. This keeps any cache from entering an Exclusive state, so caches that use three-, four- and five-state invalidation protocols can be combined behind the block. A processor built without coherence hardware is given an interrupt line instead of a snoop channel. Its software acknowledges after it has cleaned or discarded the line.

The record is a direct-mapped table indexed by line address and tagged with the upper window bits. When a new line maps onto an occupied entry, the block first clears the old line from both caches, writing dirty data to memory, and only then serves the new access. Requests are served one at a time. When both buses request at once, the bus not served last is taken first.

Top module: `coh_dir`

## Requirements
- R1: An access whose address lies outside the window (address bits above WIN_LG differ from WIN_BASE) issues one memory access with the requester's line address, write only for the write-back code. It forwards nothing and acknowledges with shared low.
- R2: A read (op 0) to a window line whose other-processor record is Invalid is served by one memory read with no forward. Afterwards the reader's record is Shared.
- R3: Every acknowledge of an in-window read pulses shared_o of that bus in the same cycle. Ownership requests and write-backs acknowledge with shared_o low.
- R4: An ownership request (op 1) while the other record is Shared first sends an invalidate (snoop code 0) to the other side, then performs a memory read. The writer's record becomes Modified and the other becomes Invalid. Both records never hold Modified together with any valid state on the other side.
- R5: A read while the other record is Modified sends a share-back snoop (code 2) to the other side, writes the line to memory, and then reads it for the requester. Both records end Shared.
- R6: An ownership request while the other record is Modified sends a flush snoop (code 1), writes the line to memory, and then reads it. The other record becomes Invalid.
- R7: When the other record is Invalid, no snoop and no interrupt is issued for the access.
- R8: For a processor marked in NOCOH, every forward to it raises irq_o for that processor, carrying the line address on snp_addr_o, in place of snp_valid_o. The forward completes on irq_ack_i.
- R9: A window access whose table entry holds a different line with a valid state first forwards to the holder on the lowest-numbered bus. It uses a flush if that holder is Modified, followed by a memory write of the old line, and an invalidate otherwise. Only after the old line is cleared does it serve the new access.
- R10: A write-back (op 2) performs a memory write and sets the writer's record to Invalid, leaving the other record unchanged.
- R11: A forward is held with stable code and address until it is completed. The requester's acknowledge never appears before it.
- R12: When both buses request in the same cycle, the bus not served most recently is served first. After reset, bus 0 wins.
- R13: During and right after reset, no acknowledge, memory request, snoop or interrupt is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 2 | Request per bus, held until acknowledged |
| req_op_i | input | 2x2 | Per bus: 0 read, 1 ownership request, 2 write-back |
| req_addr_i | input | 2xAW | Per bus byte address |
| ack_o | output | 2 | One-cycle completion pulse per bus |
| shared_o | output | 2 | Shared indication per bus, valid with ack_o |
| snp_valid_o | output | 2 | Snoop request per bus |
| snp_kind_o | output | 2x2 | Snoop code: 0 invalidate, 1 flush, 2 share-back |
| snp_addr_o | output | 2xAW | Line address of the snoop or interrupt |
| snp_done_i | input | 2 | Snoop completion per bus |
| irq_o | output | 2 | Interrupt to a processor without coherence hardware |
| irq_ack_i | input | 2 | Interrupt service completion |
| mem_valid_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write when high |
| mem_addr_o | output | AW | Memory line address |
| mem_ready_i | input | 1 | Memory completion |

## Verification
A request is taken on the first edge where it is valid. The record is consulted on the next edge. Any forward or memory request is presented one cycle after that. Each memory write-back, memory read or forward adds its handshake plus one cycle, and the acknowledge appears exactly one cycle after the final memory handshake. Responder latencies differ per channel, so the bench checks the order of events rather than absolute cycle numbers. Every snoop, interrupt, memory handshake and acknowledge is captured at the falling edge when it happens and compared in sequence against the events the requirements predict. An acknowledge that arrives early, or a forward that appears or goes missing, shows up as a mismatch in the order.

// File: rtl/coh_dir_pkg.sv
package coh_dir_pkg;
  typedef enum logic [1:0] {OP_RD = 2'd0, OP_RFO = 2'd1, OP_WB = 2'd2} op_e;
  typedef enum logic [1:0] {ST_I = 2'd0, ST_S = 2'd1, ST_M = 2'd2} lst_e;
  typedef enum logic [1:0] {SNP_INV = 2'd0, SNP_FLUSH = 2'd1, SNP_SHARE = 2'd2} snp_e;
  typedef enum logic [2:0] {
    F_IDLE, F_CHECK, F_SNOOP, F_MWB, F_MEM, F_RESP
  } fsm_e;
endpackage

// File: rtl/coh_dir_arb.sv
module coh_dir_arb (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] req_i,
  input  logic       take_i,
  output logic       gnt_o
);
  logic last_q;

  assign gnt_o = (&req_i) ? ~last_q : req_i[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     last_q <= 1'b1;
    else if (take_i) last_q <= gnt_o;
  end

  AST_GNT_REQUESTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> req_i[gnt_o]); // R12
endmodule

// File: rtl/coh_dir_table.sv
module coh_dir_table
  import coh_dir_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int TAG_W = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [IDX_W-1:0]      rd_idx_i,
  output logic                  rd_vld_o,
  output logic [TAG_W-1:0]      rd_tag_o,
  output logic [1:0][1:0]       rd_st_o,
  input  logic                  wr_en_i,
  input  logic [IDX_W-1:0]      wr_idx_i,
  input  logic [TAG_W-1:0]      wr_tag_i,
  input  logic [1:0][1:0]       wr_st_i
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0]       vld_q;
  logic [TAG_W-1:0]       tag_q [DEPTH];
  logic [1:0][1:0]        st_q  [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        tag_q[i] <= '0;
        st_q[i]  <= '0;
      end
    end else if (wr_en_i) begin
      vld_q[wr_idx_i] <= 1'b1;
      tag_q[wr_idx_i] <= wr_tag_i;
      st_q[wr_idx_i]  <= wr_st_i;
    end
  end

  assign rd_vld_o = vld_q[rd_idx_i];
  assign rd_tag_o = tag_q[rd_idx_i];
  assign rd_st_o  = st_q[rd_idx_i];

  // a Modified owner excludes any valid copy on the other side
  AST_SINGLE_OWNER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> !((wr_st_i[0] == ST_M && wr_st_i[1] != ST_I) ||
                  (wr_st_i[1] == ST_M && wr_st_i[0] != ST_I))); // R4
endmodule

// File: rtl/coh_dir_fwd.sv
module coh_dir_fwd #(
  parameter bit NO_HW = 1'b0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       go_i,
  input  logic [1:0] kind_i,
  input  logic       snp_done_i,
  input  logic       irq_ack_i,
  output logic       snp_valid_o,
  output logic [1:0] snp_kind_o,
  output logic       irq_o,
  output logic       done_o
);
  assign snp_valid_o = go_i & ~NO_HW;
  assign irq_o       = go_i &  NO_HW;
  assign snp_kind_o  = NO_HW ? 2'b00 : kind_i;
  assign done_o      = go_i & (NO_HW ? irq_ack_i : snp_done_i);

  generate
    if (NO_HW) begin : g_irq
      AST_IRQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o && !irq_ack_i |=> irq_o); // R8
    end else begin : g_bus
      AST_SNP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        snp_valid_o && !snp_done_i |=> snp_valid_o && $stable(snp_kind_o)); // R11
    end
  endgenerate
endmodule

// File: rtl/coh_dir.sv
module coh_dir
  import coh_dir_pkg::*;
#(
  parameter int             AW       = 16,
  parameter int             OFF_W    = 4,
  parameter int             IDX_W    = 4,
  parameter int             WIN_LG   = 12,
  parameter logic [AW-1:0]  WIN_BASE = 16'h4000,
  parameter logic [1:0]     NOCOH    = 2'b10
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [1:0]           req_valid_i,
  input  logic [1:0][1:0]      req_op_i,
  input  logic [1:0][AW-1:0]   req_addr_i,
  output logic [1:0]           ack_o,
  output logic [1:0]           shared_o,
  output logic [1:0]           snp_valid_o,
  output logic [1:0][1:0]      snp_kind_o,
  output logic [1:0][AW-1:0]   snp_addr_o,
  input  logic [1:0]           snp_done_i,
  output logic [1:0]           irq_o,
  input  logic [1:0]           irq_ack_i,
  output logic                 mem_valid_o,
  output logic                 mem_we_o,
  output logic [AW-1:0]        mem_addr_o,
  input  logic                 mem_ready_i
);
  localparam int TAG_W = WIN_LG - OFF_W - IDX_W;
  localparam logic [AW-1:0] LINE_MASK = {{(AW-OFF_W){1'b1}}, {OFF_W{1'b0}}};

  fsm_e           fsm_q, fsm_d;
  logic           req_q, tgt_q, gnt, cap;
  logic [1:0]     op_q, kind_q;
  logic [AW-1:0]  addr_q, vaddr_q;

  logic           in_win, hit, is_rd, oth, vsel;
  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag, rd_tag, tbl_tag;
  logic           rd_vld, tbl_we;
  logic [1:0][1:0] rd_st, tbl_st;

  logic           fw_set, fw_tgt_d;
  logic [1:0]     fw_kind_d;
  logic [AW-1:0]  fw_addr_d;
  logic [1:0]     fwd_done;

  assign in_win = addr_q[AW-1:WIN_LG] == WIN_BASE[AW-1:WIN_LG];
  assign idx    = addr_q[OFF_W +: IDX_W];
  assign tag    = addr_q[OFF_W+IDX_W +: TAG_W];
  assign hit    = rd_vld && (rd_tag == tag);
  assign is_rd  = (op_q != OP_RFO) && (op_q != OP_WB);
  assign oth    = ~req_q;
  assign vsel   = (rd_st[0] != ST_I) ? 1'b0 : 1'b1;

  coh_dir_arb u_arb (
    .clk_i, .rst_ni,
    .req_i  (req_valid_i),
    .take_i (cap),
    .gnt_o  (gnt)
  );

  coh_dir_table #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tbl (
    .clk_i, .rst_ni,
    .rd_idx_i (idx),
    .rd_vld_o (rd_vld),
    .rd_tag_o (rd_tag),
    .rd_st_o  (rd_st),
    .wr_en_i  (tbl_we),
    .wr_idx_i (idx),
    .wr_tag_i (tbl_tag),
    .wr_st_i  (tbl_st)
  );

  for (genvar p = 0; p < 2; p++) begin : g_fwd
    coh_dir_fwd #(.NO_HW(NOCOH[p])) u_fwd (
      .clk_i, .rst_ni,
      .go_i        ((fsm_q == F_SNOOP) && (tgt_q == 1'(p))),
      .kind_i      (kind_q),
      .snp_done_i  (snp_done_i[p]),
      .irq_ack_i   (irq_ack_i[p]),
      .snp_valid_o (snp_valid_o[p]),
      .snp_kind_o  (snp_kind_o[p]),
      .irq_o       (irq_o[p]),
      .done_o      (fwd_done[p])
    );
    assign snp_addr_o[p] = vaddr_q;
  end

  always_comb begin
    fsm_d     = fsm_q;
    cap       = 1'b0;
    tbl_we    = 1'b0;
    tbl_tag   = rd_tag;
    tbl_st    = rd_st;
    fw_set    = 1'b0;
    fw_tgt_d  = tgt_q;
    fw_kind_d = kind_q;
    fw_addr_d = vaddr_q;
    unique case (fsm_q)
      F_IDLE: if (|req_valid_i) begin
        cap   = 1'b1;
        fsm_d = F_CHECK;
      end
      F_CHECK: begin
        if (!in_win) begin
          fsm_d = F_MEM;
        end else if (!hit) begin
          if (rd_vld && (rd_st[0] != ST_I || rd_st[1] != ST_I)) begin
            // clear the resident line before reuse
            fw_set    = 1'b1;
            fw_tgt_d  = vsel;
            fw_kind_d = (rd_st[vsel] == ST_M) ? SNP_FLUSH : SNP_INV;
            fw_addr_d = {WIN_BASE[AW-1:WIN_LG], rd_tag, idx, {OFF_W{1'b0}}};
            fsm_d     = F_SNOOP;
          end else begin
            tbl_we  = 1'b1;
            tbl_tag = tag;
            tbl_st  = {ST_I, ST_I};
          end
        end else if (is_rd && rd_st[oth] == ST_M) begin
          fw_set    = 1'b1;
          fw_tgt_d  = oth;
          fw_kind_d = SNP_SHARE;
          fw_addr_d = addr_q;
          fsm_d     = F_SNOOP;
        end else if (op_q == OP_RFO && rd_st[oth] != ST_I) begin
          fw_set    = 1'b1;
          fw_tgt_d  = oth;
          fw_kind_d = (rd_st[oth] == ST_M) ? SNP_FLUSH : SNP_INV;
          fw_addr_d = addr_q;
          fsm_d     = F_SNOOP;
        end else begin
          fsm_d = F_MEM;
        end
      end
      F_SNOOP: if (fwd_done[tgt_q]) begin
        tbl_we        = 1'b1;
        tbl_st[tgt_q] = (kind_q == SNP_SHARE) ? ST_S : ST_I;
        fsm_d         = (kind_q == SNP_INV) ? F_CHECK : F_MWB;
      end
      F_MWB: if (mem_ready_i) fsm_d = F_CHECK;
      F_MEM: if (mem_ready_i) begin
        if (in_win) begin
          tbl_we        = 1'b1;
          tbl_st[req_q] = is_rd ? ST_S : ((op_q == OP_RFO) ? ST_M : ST_I);
        end
        fsm_d = F_RESP;
      end
      F_RESP:  fsm_d = F_IDLE;
      default: fsm_d = F_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fsm_q   <= F_IDLE;
      req_q   <= 1'b0;
      op_q    <= '0;
      addr_q  <= '0;
      tgt_q   <= 1'b0;
      kind_q  <= '0;
      vaddr_q <= '0;
    end else begin
      fsm_q <= fsm_d;
      if (cap) begin
        req_q  <= gnt;
        op_q   <= req_op_i[gnt];
        addr_q <= req_addr_i[gnt] & LINE_MASK;
      end
      if (fw_set) begin
        tgt_q   <= fw_tgt_d;
        kind_q  <= fw_kind_d;
        vaddr_q <= fw_addr_d;
      end
    end
  end

  assign mem_valid_o = (fsm_q == F_MEM) || (fsm_q == F_MWB);
  assign mem_we_o    = (fsm_q == F_MWB) || (op_q == OP_WB);
  assign mem_addr_o  = (fsm_q == F_MWB) ? vaddr_q : addr_q;

  always_comb begin
    ack_o    = '0;
    shared_o = '0;
    if (fsm_q == F_RESP) begin
      ack_o[req_q]    = 1'b1;
      shared_o[req_q] = in_win && is_rd;
    end
  end

  AST_ACK_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ack_o)); // R12
  AST_SHARED_WITH_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shared_o & ~ack_o) == 2'b00); // R3
  AST_ONE_FORWARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({snp_valid_o, irq_o})); // R8
  AST_NO_ACK_WHILE_FWD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|snp_valid_o || |irq_o) |-> ack_o == 2'b00); // R11
  AST_MEM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o && !mem_ready_i |=> mem_valid_o && $stable(mem_addr_o) && $stable(mem_we_o)); // R1
  AST_FWD_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|snp_valid_o || |irq_o) && !(|(snp_done_i & snp_valid_o)) && !(|(irq_ack_i & irq_o))
    |=> $stable(snp_addr_o)); // R11
endmodule

// File: tb/tb_coh_dir.sv
module tb_coh_dir;
  localparam int CLK_NS = 10;
  localparam int AW = 16;
  localparam int K_MEM = 0, K_SNP = 1, K_IRQ = 2, K_ACK = 3;
  localparam int A_LN = 'h4010, B_LN = 'h4110, C_LN = 'h8010, D_LN = 'h9020;

  logic clk, rst_n;
  logic [1:0] req_valid;
  logic [1:0][1:0] req_op;
  logic [1:0][AW-1:0] req_addr;
  logic [1:0] ack, shared, snp_valid, snp_done, irq, irq_ack;
  logic [1:0][1:0] snp_kind;
  logic [1:0][AW-1:0] snp_addr;
  logic mem_valid, mem_we, mem_ready;
  logic [AW-1:0] mem_addr;

  coh_dir dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_op_i(req_op), .req_addr_i(req_addr),
    .ack_o(ack), .shared_o(shared),
    .snp_valid_o(snp_valid), .snp_kind_o(snp_kind), .snp_addr_o(snp_addr),
    .snp_done_i(snp_done), .irq_o(irq), .irq_ack_i(irq_ack),
    .mem_valid_o(mem_valid), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_ready_i(mem_ready)
  );

  initial clk = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  typedef struct { int k; int bus; int sub; int addr; string tag; } ev_t;
  ev_t exp_q[$];
  int n_cmp = 0, n_bad = 0;
  int mem_cnt = 0;
  int snp_cnt [2] = '{0, 0};
  int irq_cnt [2] = '{0, 0};

  task automatic expect_ev(int k, int bus, int sub, int addr, string tag);
    ev_t e;
    e.k = k; e.bus = bus; e.sub = sub; e.addr = addr; e.tag = tag;
    exp_q.push_back(e);
  endtask

  function automatic void observe(int k, int bus, int sub, int addr);
    ev_t e;
    n_cmp++;
    if (exp_q.size() == 0) begin
      n_bad++;
      $display("FAIL unexpected event: actual k=%0d bus=%0d sub=%0d addr=%h expected none",
               k, bus, sub, addr);
      return;
    end
    e = exp_q.pop_front();
    if (e.k != k || e.bus != bus || e.sub != sub || e.addr != addr) begin
      n_bad++;
      $display("FAIL %s: actual k=%0d bus=%0d sub=%0d addr=%h expected k=%0d bus=%0d sub=%0d addr=%h",
               e.tag, k, bus, sub, addr, e.k, e.bus, e.sub, e.addr);
    end
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // monitor and responders: sample and drive away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      for (int b = 0; b < 2; b++)
        if (ack[b]) observe(K_ACK, b, int'(shared[b]), 0);
      if (mem_ready) begin
        mem_ready = 1'b0; mem_cnt = 0;
      end else if (mem_valid) begin
        mem_cnt++;
        if (mem_cnt >= 1) begin
          observe(K_MEM, 0, int'(mem_we), int'(mem_addr));
          mem_ready = 1'b1;
        end
      end
      for (int b = 0; b < 2; b++) begin
        if (snp_done[b]) begin
          snp_done[b] = 1'b0; snp_cnt[b] = 0;
        end else if (snp_valid[b]) begin
          snp_cnt[b]++;
          if (snp_cnt[b] >= 4) begin
            observe(K_SNP, b, int'(snp_kind[b]), int'(snp_addr[b]));
            snp_done[b] = 1'b1;
          end
        end
        if (irq_ack[b]) begin
          irq_ack[b] = 1'b0; irq_cnt[b] = 0;
        end else if (irq[b]) begin
          irq_cnt[b]++;
          if (irq_cnt[b] >= 2) begin
            observe(K_IRQ, b, 0, int'(snp_addr[b]));
            irq_ack[b] = 1'b1;
          end
        end
      end
    end
  end

  task automatic do_req(int b, int op, int addr);
    @(negedge clk);
    req_op[b]    = 2'(op);
    req_addr[b]  = AW'(addr);
    req_valid[b] = 1'b1;
    do @(negedge clk); while (!ack[b]);
    req_valid[b] = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = '0; req_op = '0; req_addr = '0;
    snp_done = '0; irq_ack = '0; mem_ready = 1'b0;
    repeat (3) @(negedge clk);
    // R13 idle outputs in reset
    chk(ack == 0 && !mem_valid && snp_valid == 0 && irq == 0, "R13 in reset",
        int'({ack, mem_valid, snp_valid, irq}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(ack == 0 && !mem_valid && snp_valid == 0 && irq == 0, "R13 after reset",
        int'({ack, mem_valid, snp_valid, irq}), 0);

    // R1 outside window
    expect_ev(K_MEM, 0, 0, C_LN, "R1 mem read");
    expect_ev(K_ACK, 0, 0, 0, "R1 ack without shared");
    do_req(0, 0, C_LN + 3);

    // R2 read with other Invalid, R3 shared on read
    expect_ev(K_MEM, 0, 0, A_LN, "R2 mem read");
    expect_ev(K_ACK, 1, 1, 0, "R3 shared on read");
    do_req(1, 0, A_LN + 4);

    expect_ev(K_MEM, 0, 0, A_LN, "R2 second reader");
    expect_ev(K_ACK, 0, 1, 0, "R3 shared on second read");
    do_req(0, 0, A_LN);

    // R4 + R8: invalidate of non-coherent processor 1 via interrupt
    expect_ev(K_IRQ, 1, 0, A_LN, "R8 irq instead of snoop");
    expect_ev(K_MEM, 0, 0, A_LN, "R4 fetch after invalidate");
    expect_ev(K_ACK, 0, 0, 0, "R3 no shared on ownership");
    do_req(0, 1, A_LN);

    // R5 + R11: share-back snoop on bus 0, ack held behind it
    expect_ev(K_SNP, 0, 2, A_LN, "R5 share-back snoop");
    expect_ev(K_MEM, 0, 1, A_LN, "R5 memory update");
    expect_ev(K_MEM, 0, 0, A_LN, "R5 read after update");
    expect_ev(K_ACK, 1, 1, 0, "R11 ack after forward");
    do_req(1, 0, A_LN);

    // R4: invalidate snoop on coherent bus 0
    expect_ev(K_SNP, 0, 0, A_LN, "R4 invalidate snoop");
    expect_ev(K_MEM, 0, 0, A_LN, "R4 fetch");
    expect_ev(K_ACK, 1, 0, 0, "R4 ack");
    do_req(1, 1, A_LN);

    // R6 via interrupt on non-coherent holder
    expect_ev(K_IRQ, 1, 0, A_LN, "R8 irq flush");
    expect_ev(K_MEM, 0, 1, A_LN, "R6 write dirty line");
    expect_ev(K_MEM, 0, 0, A_LN, "R6 fetch");
    expect_ev(K_ACK, 0, 0, 0, "R6 ack");
    do_req(0, 1, A_LN);

    // R6 flush snoop on bus 0
    expect_ev(K_SNP, 0, 1, A_LN, "R6 flush snoop");
    expect_ev(K_MEM, 0, 1, A_LN, "R6 write dirty line");
    expect_ev(K_MEM, 0, 0, A_LN, "R6 fetch");
    expect_ev(K_ACK, 1, 0, 0, "R6 ack");
    do_req(1, 1, A_LN);

    // R10 write-back
    expect_ev(K_MEM, 0, 1, A_LN, "R10 write-back");
    expect_ev(K_ACK, 1, 0, 0, "R10 ack");
    do_req(1, 2, A_LN);

    // R7 + R10: both records Invalid, no forward
    expect_ev(K_MEM, 0, 0, A_LN, "R7 no forward, fetch only");
    expect_ev(K_ACK, 0, 0, 0, "R7 ack");
    do_req(0, 1, A_LN);

    // R12 simultaneous requests, bus 0 served last so bus 1 first
    expect_ev(K_MEM, 0, 0, D_LN, "R12 bus 1 first");
    expect_ev(K_ACK, 1, 0, 0, "R12 bus 1 ack");
    expect_ev(K_MEM, 0, 0, C_LN, "R12 bus 0 second");
    expect_ev(K_ACK, 0, 0, 0, "R12 bus 0 ack");
    fork
      do_req(0, 0, C_LN);
      do_req(1, 0, D_LN);
    join

    // R9 conflicting line evicts Modified holder on bus 0
    expect_ev(K_SNP, 0, 1, A_LN, "R9 evict flush");
    expect_ev(K_MEM, 0, 1, A_LN, "R9 evict write");
    expect_ev(K_MEM, 0, 0, B_LN, "R9 new line read");
    expect_ev(K_ACK, 1, 1, 0, "R9 ack");
    do_req(1, 0, B_LN);

    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R11 all expected events seen", exp_q.size(), 0);
    summary();
    $finish;
  end
endmodule